// File: doc/BRIEF.md
# Column Gray-Code Single-Slope Digitizer

This block is the digital half of a per-pixel single-slope conversion for a column of pixels. One counter per column advances on every fast clock. It is kept in Gray code, so a pixel that samples it at an arbitrary instant sees at most one bit in transition. A frame-start pulse restarts the counter at zero. Every pixel in the column watches a comparator line. The first rising edge on that line, after the pixel's own ramp has begun, freezes the shared count into the pixel. The pixel then converts the frozen Gray value to binary and emits it for one cycle with a strobe.

Each pixel carries a small offset trim. The trim holds back the start of the pixel's local ramp by that number of counter clocks, and comparator edges during that interval are discarded. A pixel whose comparator never rises before the counter reaches full scale reports all ones. A static mode input chooses 8-bit conversions (full scale 255) or 9-bit conversions (full scale 511). One conversion runs per frame, and a new frame start abandons any conversion still in progress.

Top module: `ssadc_column`

## Requirements
- R1: While reset is high and on the first cycle after it, every `conv_valid` bit is 0 and every `conv_word` field is 0.
- R2: The column counter holds 0 on the cycle after `frame_start` is sampled. It then advances by one binary step per clock and stops at full scale. Its Gray value changes by at most one bit per clock, except when a frame start resets it.
- R3: Call the clock edge that samples `frame_start` high edge F. If a pixel's comparator is first seen high at edge F+1+k, with no earlier edge allowed to count, the pixel reports the binary value k. `conv_valid` for that pixel is high in the cycle that follows edge F+1+k.
- R4: The pixel's offset field (5 bits, value d, pixel p at bits [5p+4:5p]) is sampled at frame start. A comparator rising edge seen at edge F+1+k with k < d is ignored, so no pixel reports a value below its offset.
- R5: A pixel reports one conversion per frame. Comparator edges after its capture are ignored until the next frame start, and `conv_valid` is high for exactly one cycle.
- R6: If no counted comparator edge has arrived by the time the counter reaches full scale, the pixel reports full scale (all ones in the active width) at edge F+1+FS. An edge seen at that same edge gives the same value.
- R7: `wide_mode` = 1 selects 9-bit conversions (FS = 511) and `wide_mode` = 0 selects 8-bit conversions (FS = 255). Pixel p's word is `conv_word[9p+8:9p]`, and its top bit is 0 in 8-bit mode.
- R8: A `frame_start` that arrives while a conversion is pending abandons that conversion without a strobe and begins a new one.
- R9: `conv_word` holds its value in every cycle in which `conv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that restarts the column counter and all pixels |
| wide_mode | input | 1 | Static resolution select: 1 = 9-bit, 0 = 8-bit |
| pix_offset | input | NPIX*OW | Per-pixel ramp start delay in counter clocks |
| comp_in | input | NPIX | Per-pixel comparator output |
| conv_word | output | NPIX*CW | Per-pixel binary conversion result |
| conv_valid | output | NPIX | Per-pixel one-cycle result strobe |

## Verification
Each fault shows up at the ports within one frame, and every fault yields a wrong word, an extra strobe or a missing strobe. A counter that skips or repeats, or a wrong Gray-to-binary mapping, shifts the reported value away from the edge index. The bench places edges at code boundaries such as 127/128 and 255/256 so that a bad bit decode is caught. A pixel that does not disarm after capture gives a second strobe on the second comparator edge of every frame. A wrong offset or saturation decision changes the value within the same frame.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  parameter int unsigned SSADC_MAX_W = 16;

  function automatic logic [SSADC_MAX_W-1:0] bin2gray(input logic [SSADC_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [SSADC_MAX_W-1:0] gray2bin(input logic [SSADC_MAX_W-1:0] g);
    logic [SSADC_MAX_W-1:0] b;
    b[SSADC_MAX_W-1] = g[SSADC_MAX_W-1];
    for (int i = SSADC_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/ssadc_gray_counter.sv
module ssadc_gray_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [CW-1:0] full_scale,
  output logic [CW-1:0] gray_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_start) begin
      cnt_d = '0;
    end else if (cnt_q != full_scale) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gray_o <= '0;
      full_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      gray_o <= CW'(ssadc_pkg::bin2gray(ssadc_pkg::SSADC_MAX_W'(cnt_d)));
      full_o <= (cnt_d == full_scale);
    end
  end
endmodule

// File: rtl/ssadc_ramp_delay.sv
module ssadc_ramp_delay #(
  parameter int unsigned OW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [OW-1:0] offset,
  output logic          armed_o
);
  logic [OW-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
    end else if (frame_start) begin
      dly_q <= offset;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  assign armed_o = (dly_q == '0);
endmodule

// File: rtl/ssadc_pixel_capture.sv
module ssadc_pixel_capture #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          armed,
  input  logic          comp,
  input  logic [CW-1:0] gray_i,
  input  logic          full_i,
  input  logic [CW-1:0] full_scale,
  output logic [CW-1:0] word_o,
  output logic          valid_o
);
  logic comp_q;
  logic active_q;
  logic hit;
  logic [CW-1:0] gray_bin;

  assign hit      = armed & comp & ~comp_q;
  assign gray_bin = CW'(ssadc_pkg::gray2bin(ssadc_pkg::SSADC_MAX_W'(gray_i)));

  always_ff @(posedge clk) begin
    if (rst) begin
      comp_q   <= 1'b0;
      active_q <= 1'b0;
      word_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      comp_q  <= comp;
      valid_o <= 1'b0;
      if (frame_start) begin
        active_q <= 1'b1;
      end else if (active_q && (hit || full_i)) begin
        word_o   <= hit ? gray_bin : full_scale;
        valid_o  <= 1'b1;
        active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssadc_column.sv
module ssadc_column #(
  parameter int unsigned NPIX = 4,
  parameter int unsigned CW   = 9,
  parameter int unsigned LW   = 8,
  parameter int unsigned OW   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               wide_mode,
  input  logic [NPIX*OW-1:0] pix_offset,
  input  logic [NPIX-1:0]    comp_in,
  output logic [NPIX*CW-1:0] conv_word,
  output logic [NPIX-1:0]    conv_valid
);
  localparam logic [CW-1:0] FS_WIDE   = CW'((1 << CW) - 1);
  localparam logic [CW-1:0] FS_NARROW = CW'((1 << LW) - 1);

  logic [CW-1:0] fs_sel;
  logic [CW-1:0] gray_bus;
  logic          full_flag;

  assign fs_sel = wide_mode ? FS_WIDE : FS_NARROW;

  ssadc_gray_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .full_scale (fs_sel),
    .gray_o     (gray_bus),
    .full_o     (full_flag)
  );

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic armed;

    ssadc_ramp_delay #(.OW(OW)) u_dly (
      .clk        (clk),
      .rst        (rst),
      .frame_start(frame_start),
      .offset     (pix_offset[p*OW +: OW]),
      .armed_o    (armed)
    );

    ssadc_pixel_capture #(.CW(CW)) u_cap (
      .clk        (clk),
      .rst        (rst),
      .frame_start(frame_start),
      .armed      (armed),
      .comp       (comp_in[p]),
      .gray_i     (gray_bus),
      .full_i     (full_flag),
      .full_scale (fs_sel),
      .word_o     (conv_word[p*CW +: CW]),
      .valid_o    (conv_valid[p])
    );
  end
endmodule

// File: rtl/ssadc_column_chk.sv
module ssadc_column_chk #(
  parameter int unsigned NPIX = 4,
  parameter int unsigned CW   = 9,
  parameter int unsigned OW   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic [CW-1:0]      gray,
  input logic [CW-1:0]      fs,
  input logic [NPIX*OW-1:0] offs,
  input logic [NPIX*CW-1:0] word,
  input logic [NPIX-1:0]    valid
);
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (gray == '0));

  a_r2_gray_step: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) |-> ($countones(gray ^ $past(gray)) <= 1));

  for (genvar p = 0; p < NPIX; p++) begin : g_chk
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
      valid[p] |=> !valid[p]);

    a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
      !valid[p] |-> $stable(word[p*CW +: CW]));

    a_r6_word_in_range: assert property (@(posedge clk) disable iff (rst)
      valid[p] |-> (word[p*CW +: CW] <= fs));

    a_r4_offset_floor: assert property (@(posedge clk) disable iff (rst)
      valid[p] |-> (word[p*CW +: CW] >= CW'(offs[p*OW +: OW])));
  end
endmodule

bind ssadc_column ssadc_column_chk #(.NPIX(NPIX), .CW(CW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .gray       (gray_bus),
  .fs         (fs_sel),
  .offs       (pix_offset),
  .word       (conv_word),
  .valid      (conv_valid)
);

// File: tb/ssadc_column_bench.sv
module ssadc_column_bench;
  localparam int NPIX = 4;
  localparam int CW   = 9;
  localparam int OW   = 5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               frame_start = 1'b0;
  logic               wide_mode = 1'b0;
  logic [NPIX*OW-1:0] pix_offset = '0;
  logic [NPIX-1:0]    comp_in = '0;
  logic [NPIX*CW-1:0] conv_word;
  logic [NPIX-1:0]    conv_valid;

  int errors = 0;
  int checks = 0;
  int kv[NPIX];
  int ov[NPIX];
  int exp_pix[$];
  int exp_val[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  ssadc_column #(.NPIX(NPIX), .CW(CW), .LW(8), .OW(OW)) u_ssadc_column (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wide_mode(wide_mode),
    .pix_offset(pix_offset), .comp_in(comp_in),
    .conv_word(conv_word), .conv_valid(conv_valid)
  );

  function automatic bit comp_at(int k, int j);
    return (k >= 0) && ((j >= k && j <= k + 2) || j >= k + 6);
  endfunction

  function automatic int expect_of(int k, int off, int fs);
    if (k < 0) return fs;
    if (k >= off && k < fs) return k;
    if (k + 6 >= off && k + 6 < fs) return k + 6;
    return fs;
  endfunction

  task automatic run_frame(input bit m9, input int abort_at, input string tag);
    int fs;
    fs = m9 ? 511 : 255;
    @(negedge clk);
    wide_mode = m9;
    comp_in = '0;
    for (int p = 0; p < NPIX; p++) pix_offset[p*OW +: OW] = OW'(ov[p]);
    frame_start = 1'b1;
    if (abort_at < 0) begin
      for (int p = 0; p < NPIX; p++) begin
        exp_pix.push_back(p);
        exp_val.push_back(expect_of(kv[p], ov[p], fs));
        exp_tag.push_back(tag);
      end
    end
    @(negedge clk);
    frame_start = 1'b0;
    for (int j = 0; j <= fs + 2; j++) begin
      if (abort_at >= 0 && j == abort_at) break;
      for (int p = 0; p < NPIX; p++) comp_in[p] = comp_at(kv[p], j);
      @(negedge clk);
    end
    if (abort_at < 0) begin
      comp_in = '0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_frame(input int k0, k1, k2, k3, o0, o1, o2, o3);
    kv[0] = k0; kv[1] = k1; kv[2] = k2; kv[3] = k3;
    ov[0] = o0; ov[1] = o1; ov[2] = o2; ov[3] = o3;
  endtask

  // Monitor: match each strobe against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int p = 0; p < NPIX; p++) begin
          if (conv_valid[p]) begin
            int idx;
            int got;
            idx = -1;
            got = int'(conv_word[p*CW +: CW]);
            for (int i = 0; i < exp_pix.size(); i++) begin
              if (idx < 0 && exp_pix[i] == p) idx = i;
            end
            checks++;
            if (idx < 0) begin
              errors++;
              $display("FAIL R5 pixel %0d unexpected strobe: actual %0d expected none", p, got);
            end else begin
              if (got != exp_val[idx]) begin
                errors++;
                $display("FAIL %s pixel %0d: actual %0d expected %0d", exp_tag[idx], p, got, exp_val[idx]);
              end
              exp_pix.delete(idx);
              exp_val.delete(idx);
              exp_tag.delete(idx);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    checks++;
    if (conv_valid != '0 || conv_word != '0) begin
      errors++;
      $display("FAIL R1 during reset: actual valid=%0h word=%0h expected 0", conv_valid, conv_word);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (conv_valid != '0 || conv_word != '0) begin
      errors++;
      $display("FAIL R1 after reset: actual valid=%0h word=%0h expected 0", conv_valid, conv_word);
    end

    // R3 R7: 8-bit values around the 127/128 Gray boundary
    set_frame(0, 5, 127, 128, 0, 0, 0, 0);
    run_frame(1'b0, -1, "R3");
    // R4: offsets mask early edges, second edge may count
    set_frame(1, 40, 3, 7, 3, 31, 10, 7);
    run_frame(1'b0, -1, "R4");
    // R6 R7: 8-bit saturation at 255
    set_frame(254, 255, 300, -1, 0, 0, 0, 0);
    run_frame(1'b0, -1, "R6");
    // R7 R6: 9-bit mode values across 255/256 and saturation at 511
    set_frame(255, 256, 510, -1, 0, 0, 0, 0);
    run_frame(1'b1, -1, "R7");
    // R4 R6: largest offset in 9-bit mode
    set_frame(31, 30, 0, 400, 31, 31, 31, 31);
    run_frame(1'b1, -1, "R4");
    // R8: abandon a pending frame, then a clean one
    set_frame(100, 120, 140, -1, 0, 0, 0, 0);
    run_frame(1'b0, 50, "R8");
    set_frame(2, 3, 4, 5, 0, 1, 2, 3);
    run_frame(1'b0, -1, "R8");
    // R5: comparator edges in every frame include a second ignored edge
    set_frame(10, 20, 30, 40, 0, 0, 0, 0);
    run_frame(1'b1, -1, "R5");

    repeat (5) @(negedge clk);
    checks++;
    if (exp_pix.size() != 0) begin
      errors++;
      $display("FAIL R3 missing strobes: actual %0d outstanding expected 0", exp_pix.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule